// File: doc/BRIEF.md
# Bidirectional Accumulator Shifter

This block shifts a 40-bit signed accumulator value in one cycle and writes the result back into a result register along with zero and sign flags. Carry and overflow are always cleared. Three kinds of shift are supported. The first is a fixed move of 16 places, either left or to the right in logical or arithmetic form. The second takes a 6-bit count from an immediate field, and two selector bits in that field choose both the direction and the kind of shift. The third takes a signed 7-bit count from the low bits of a 16-bit register word. For this signed count, the sign of the value flips the direction, and each operation defines which direction a positive count means.

The operand arrives on `acc_in` from the accumulator file. The shifter itself is a combinational barrel. The registered result appears on `acc_out` one clock after `exec_en` is sampled high. When `exec_en` is low, every output holds its value.

Top module: `acc_shifter_top`

## Requirements
- R1: A synchronous active-low reset sets `acc_out` to 0, `flag_zero` to 1, and `flag_sign`, `flag_carry` and `flag_ovf` to 0.
- R2: While `exec_en` is low, `acc_out` and all four flags keep their values, whatever the other inputs do.
- R3: The fixed operations are selected by `op_sel`: 0 shifts left by 16, 1 shifts right logically by 16, and 2 shifts right arithmetically by 16.
- R4: `op_sel`=3 uses `imm_field`. Bits 7:6 select 00 logical left, 01 logical right, 10 arithmetic left (identical to logical left) or 11 arithmetic right. For left shifts the amount is bits 5:0.
- R5: For an immediate right shift, the amount is 0 when bits 5:0 are zero, and otherwise 64 minus bits 5:0.
- R6: The signed count comes from `cnt_src`. Bits 5:0 give the magnitude field and bit 6 is the sign. The count is the field when bit 6 is clear and the field minus 64 when bit 6 is set. The count is 0 whenever the field is zero, and bits 15:7 are ignored.
- R7: `op_sel`=4 is a logical shift and `op_sel`=5 is an arithmetic shift. For both, a positive count shifts right and a negative count shifts left by its magnitude.
- R8: `op_sel`=6 is a logical shift and `op_sel`=7 is an arithmetic shift. For both, a positive count shifts left and a negative count shifts right by its magnitude.
- R9: A logical right shift treats the operand as unsigned 40-bit and fills with zeros. An arithmetic right shift fills with copies of bit 39.
- R10: For amounts of 40 or more, logical shifts give zero and arithmetic right shifts give 40 copies of bit 39.
- R11: With each result, `flag_zero` is set exactly when the result is zero and `flag_sign` equals result bit 39. `flag_carry` and `flag_ovf` are 0.
- R12: The result of an operation sampled with `exec_en` high is on `acc_out` immediately after that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Capture the shifter result at this edge |
| op_sel | input | 3 | Operation select (0..7) |
| imm_field | input | 8 | Immediate: bits 7:6 kind, bits 5:0 amount field |
| cnt_src | input | 16 | Register word holding the signed 7-bit count |
| acc_in | input | 40 | Accumulator operand |
| acc_out | output | 40 | Registered shift result |
| flag_zero | output | 1 | Result equals zero |
| flag_sign | output | 1 | Result bit 39 |
| flag_carry | output | 1 | Always cleared on update |
| flag_ovf | output | 1 | Always cleared on update |

## Verification
The block has a single register stage, so a wrong internal decision shows up at the ports one edge after the operation. A wrong decode of direction or amount, or a wrong fill bit, gives an `acc_out` that differs from the behavioural model at the next comparison. A flag register that drifts from the result shows up as a disagreement between `flag_zero` or `flag_sign` and `acc_out` in that same cycle. Directed cases cover the corner cases: counts with a zero field, counts near ±64, amounts of 40 or more, and ignored upper count bits. Randomised traffic with gaps in `exec_en` covers hold behaviour and mixed operations.

// File: rtl/acc_shift_pkg.sv
// Shared constants and operation codes for the accumulator shifter.
package acc_shift_pkg;
    localparam int ACC_WIDTH   = 40;  // accumulator width
    localparam int AMT_WIDTH   = 6;   // shift amount / field width
    localparam int SRC_WIDTH   = 16;  // count register word width
    localparam int FIXED_SHIFT = 16;  // amount of the fixed operations

    typedef enum logic [2:0] {
        OP_SHL16  = 3'd0,
        OP_SHR16L = 3'd1,
        OP_SHR16A = 3'd2,
        OP_IMM    = 3'd3,
        OP_VAR_RL = 3'd4,  // positive count -> right, logical
        OP_VAR_RA = 3'd5,  // positive count -> right, arithmetic
        OP_VAR_LL = 3'd6,  // positive count -> left, logical
        OP_VAR_LA = 3'd7   // positive count -> left, arithmetic
    } shift_op_e;
endpackage

// File: rtl/acc_shift_decode.sv
// Turns an operation code, immediate and count word into direction,
// fill kind and unsigned amount. Assumes SRC_W > AMT_W.
module acc_shift_decode
    import acc_shift_pkg::*;
#(
    parameter int AMT_W   = AMT_WIDTH,
    parameter int SRC_W   = SRC_WIDTH,
    parameter int FIX_AMT = FIXED_SHIFT
) (
    input  logic [2:0]       op_sel,
    input  logic [AMT_W+1:0] imm_field,
    input  logic [SRC_W-1:0] cnt_src,
    output logic             go_left,
    output logic             arith,
    output logic [AMT_W-1:0] amt
);
    localparam logic [AMT_W-1:0] FIX = AMT_W'(FIX_AMT);

    logic [AMT_W-1:0] imm_f;
    logic [1:0]       imm_kind;
    logic [AMT_W-1:0] var_f;
    logic             var_neg;
    logic [AMT_W-1:0] var_mag;
    logic             unused_cnt_hi;

    assign unused_cnt_hi = ^cnt_src[SRC_W-1:AMT_W+1];

    // Split the fields and take the magnitude of the signed count.
    always_comb begin
        imm_f    = imm_field[AMT_W-1:0];
        imm_kind = imm_field[AMT_W+1:AMT_W];
        var_f    = cnt_src[AMT_W-1:0];
        var_neg  = cnt_src[AMT_W] && (var_f != '0);
        var_mag  = var_neg ? (~var_f + 1'b1) : var_f;
    end

    // Select direction, fill and amount per operation.
    always_comb begin
        go_left = 1'b0;
        arith   = 1'b0;
        amt     = '0;
        unique case (shift_op_e'(op_sel))
            OP_SHL16:  begin go_left = 1'b1; amt = FIX; end
            OP_SHR16L: begin amt = FIX; end
            OP_SHR16A: begin arith = 1'b1; amt = FIX; end
            OP_IMM: begin
                go_left = ~imm_kind[0];
                arith   = imm_kind[1];
                amt     = imm_kind[0] ? (~imm_f + 1'b1) : imm_f;
            end
            OP_VAR_RL: begin go_left = var_neg;  amt = var_mag; end
            OP_VAR_RA: begin go_left = var_neg;  arith = 1'b1; amt = var_mag; end
            OP_VAR_LL: begin go_left = ~var_neg; amt = var_mag; end
            OP_VAR_LA: begin go_left = ~var_neg; arith = 1'b1; amt = var_mag; end
            default:   begin amt = '0; end
        endcase
    end
endmodule

// File: rtl/acc_shift_barrel.sv
// Log-staged barrel shifter, left or right, with zero or sign fill.
// Stages whose step reaches the width flush the whole word.
module acc_shift_barrel
    import acc_shift_pkg::*;
#(
    parameter int ACC_W = ACC_WIDTH,
    parameter int AMT_W = AMT_WIDTH
) (
    input  logic [ACC_W-1:0] operand,
    input  logic             go_left,
    input  logic             arith,
    input  logic [AMT_W-1:0] amt,
    output logic [ACC_W-1:0] result
);
    logic             fill;
    logic [ACC_W-1:0] stage [0:AMT_W];

    assign fill     = arith & ~go_left & operand[ACC_W-1];
    assign stage[0] = operand;

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        localparam int STEP = 1 << g;
        logic [ACC_W-1:0] moved;
        if (STEP >= ACC_W) begin : g_flush
            // Step covers the whole word: only fill remains.
            assign moved = go_left ? '0 : {ACC_W{fill}};
        end else begin : g_shift
            // Shift by this stage's power of two.
            assign moved = go_left ? {stage[g][ACC_W-1-STEP:0], {STEP{1'b0}}}
                                   : {{STEP{fill}}, stage[g][ACC_W-1:STEP]};
        end
        assign stage[g+1] = amt[g] ? moved : stage[g];
    end

    assign result = stage[AMT_W];
endmodule

// File: rtl/acc_shift_flags.sv
// Zero and sign flags of a shifter result.
module acc_shift_flags
    import acc_shift_pkg::*;
#(
    parameter int ACC_W = ACC_WIDTH
) (
    input  logic [ACC_W-1:0] value,
    output logic             is_zero,
    output logic             is_neg
);
    // Derive both flags from the full-width value.
    always_comb begin
        is_zero = (value == '0);
        is_neg  = value[ACC_W-1];
    end
endmodule

// File: rtl/acc_shifter_top.sv
// Single-cycle accumulator shifter with registered result and flags.
// Assumes the operand on acc_in is stable around the enabled edge.
module acc_shifter_top
    import acc_shift_pkg::*;
#(
    parameter int ACC_W   = ACC_WIDTH,
    parameter int AMT_W   = AMT_WIDTH,
    parameter int SRC_W   = SRC_WIDTH,
    parameter int FIX_AMT = FIXED_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_en,
    input  logic [2:0]       op_sel,
    input  logic [AMT_W+1:0] imm_field,
    input  logic [SRC_W-1:0] cnt_src,
    input  logic [ACC_W-1:0] acc_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             flag_zero,
    output logic             flag_sign,
    output logic             flag_carry,
    output logic             flag_ovf
);
    logic             dir_left;
    logic             fill_arith;
    logic [AMT_W-1:0] shift_amt;
    logic [ACC_W-1:0] shifted;
    logic             nxt_zero;
    logic             nxt_sign;

    acc_shift_decode #(.AMT_W(AMT_W), .SRC_W(SRC_W), .FIX_AMT(FIX_AMT)) u_decode (
        .op_sel    (op_sel),
        .imm_field (imm_field),
        .cnt_src   (cnt_src),
        .go_left   (dir_left),
        .arith     (fill_arith),
        .amt       (shift_amt)
    );

    acc_shift_barrel #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_barrel (
        .operand (acc_in),
        .go_left (dir_left),
        .arith   (fill_arith),
        .amt     (shift_amt),
        .result  (shifted)
    );

    acc_shift_flags #(.ACC_W(ACC_W)) u_flags (
        .value   (shifted),
        .is_zero (nxt_zero),
        .is_neg  (nxt_sign)
    );

    // Capture result and flags on enabled edges; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out    <= '0;
            flag_zero  <= 1'b1;
            flag_sign  <= 1'b0;
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
        end else if (exec_en) begin
            acc_out    <= shifted;
            flag_zero  <= nxt_zero;
            flag_sign  <= nxt_sign;
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
        end
    end
endmodule

// File: rtl/acc_shifter_checker.sv
// Port-level properties of the accumulator shifter, bound to the top.
module acc_shifter_checker
    import acc_shift_pkg::*;
#(
    parameter int ACC_W   = ACC_WIDTH,
    parameter int AMT_W   = AMT_WIDTH,
    parameter int SRC_W   = SRC_WIDTH,
    parameter int FIX_AMT = FIXED_SHIFT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_en,
    input logic [2:0]       op_sel,
    input logic [AMT_W+1:0] imm_field,
    input logic [SRC_W-1:0] cnt_src,
    input logic [ACC_W-1:0] acc_in,
    input logic [ACC_W-1:0] acc_out,
    input logic             flag_zero,
    input logic             flag_sign,
    input logic             flag_carry,
    input logic             flag_ovf
);
    logic unused_imm;
    assign unused_imm = ^imm_field;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(acc_out) && $stable(flag_zero) && $stable(flag_sign)
                      && $stable(flag_carry) && $stable(flag_ovf))); // R2

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero == (acc_out == '0)); // R11

    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sign == acc_out[ACC_W-1]); // R11

    AST_SHL16_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_SHL16) |=> (acc_out[FIX_AMT-1:0] == '0)); // R3

    AST_SHR16L_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_SHR16L) |=> (acc_out[ACC_W-1:ACC_W-FIX_AMT] == '0)); // R9

    AST_SHR16A_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_SHR16A)
        |=> (acc_out[ACC_W-1:ACC_W-FIX_AMT-1] == {(FIX_AMT+1){$past(acc_in[ACC_W-1])}})); // R9

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel[2] && cnt_src[AMT_W-1:0] == '0) |=> (acc_out == $past(acc_in))); // R6
endmodule

bind acc_shifter_top acc_shifter_checker #(
    .ACC_W(ACC_W), .AMT_W(AMT_W), .SRC_W(SRC_W), .FIX_AMT(FIX_AMT)
) u_checker (.*);

// File: tb/acc_shifter_top_bench.sv
`timescale 1ns/1ps
module acc_shifter_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [7:0]  imm_field = '0;
    logic [15:0] cnt_src = '0;
    logic [39:0] acc_in = '0;
    logic [39:0] acc_out;
    logic        flag_zero, flag_sign, flag_carry, flag_ovf;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    logic [39:0] exp_acc;
    logic        exp_z, exp_s;
    string       exp_tag = "R1";
    string       cur_tag = "R1";

    always #2.5 clk = ~clk;

    acc_shifter_top u_acc_shifter_top (.*);

    // Behavioural shift model: integer arithmetic, no staging.
    function automatic logic [39:0] model(input logic [2:0] op, input logic [7:0] imm,
                                          input logic [15:0] cnt, input logic [39:0] a);
        longint u = longint'({24'b0, a});
        longint s = longint'({{24{a[39]}}, a});
        longint r;
        int n = 0;
        bit left = 0, ar = 0;
        case (op)
            3'd0: begin left = 1; n = 16; end
            3'd1: begin left = 0; n = 16; end
            3'd2: begin left = 0; ar = 1; n = 16; end
            3'd3: begin
                int f = int'(imm[5:0]);
                ar = imm[7];
                left = !imm[6];
                n = left ? f : ((f == 0) ? 0 : 64 - f);
            end
            default: begin
                int f = int'(cnt[5:0]);
                int v = (f == 0) ? 0 : (cnt[6] ? f - 64 : f);
                bit pos_right = (op == 3'd4 || op == 3'd5);
                ar = (op == 3'd5 || op == 3'd7);
                if (v >= 0) begin left = !pos_right; n = v; end
                else begin left = pos_right; n = -v; end
            end
        endcase
        if (left) r = u << n;
        else if (ar) r = s >>> n;
        else r = u >> n;
        return r[39:0];
    endfunction

    // Reference state updated on each edge from the sampled inputs.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            exp_acc <= '0; exp_z <= 1'b1; exp_s <= 1'b0; exp_tag <= "R1";
        end else if (exec_en) begin
            logic [39:0] r;
            r = model(op_sel, imm_field, cnt_src, acc_in);
            exp_acc <= r; exp_z <= (r == 0); exp_s <= r[39]; exp_tag <= cur_tag;
        end else begin
            exp_tag <= "R2";
        end
    end

    // Compare outputs to the model mid-cycle.
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (acc_out !== exp_acc || flag_zero !== exp_z || flag_sign !== exp_s
                || flag_carry !== 1'b0 || flag_ovf !== 1'b0) begin
                n_fail++;
                $display("FAIL %s (R11/R12): acc=%h z%0b s%0b c%0b v%0b expected acc=%h z%0b s%0b c0 v0",
                         exp_tag, acc_out, flag_zero, flag_sign, flag_carry, flag_ovf,
                         exp_acc, exp_z, exp_s);
            end
        end
    end

    task automatic run_op(input logic [2:0] op, input logic [7:0] imm, input logic [15:0] cnt,
                          input logic [39:0] a, input string tag);
        @(negedge clk);
        exec_en = 1'b1; op_sel = op; imm_field = imm; cnt_src = cnt; acc_in = a; cur_tag = tag;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exec_en = 1'b0; op_sel = 3'($urandom); imm_field = 8'($urandom);
            cnt_src = 16'($urandom); acc_in = {8'($urandom), 32'($urandom)};
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);                  // R1 reset values checked
        rst_n = 1'b1;
        run_op(3'd0, 8'h00, 16'h0, 40'h00_1234_5678, "R3");   // -> 34_5678_0000
        run_op(3'd1, 8'h00, 16'h0, 40'h80_0000_0001, "R3");   // R9 zero fill
        run_op(3'd2, 8'h00, 16'h0, 40'h80_0000_0001, "R3");   // R9 sign fill
        run_op(3'd3, 8'h04, 16'h0, 40'h00_0000_00F1, "R4");   // left 4
        run_op(3'd3, 8'h84, 16'h0, 40'h00_0000_00F1, "R4");   // arith left 4
        run_op(3'd3, 8'h40, 16'h0, 40'h9A_BCDE_F012, "R5");   // field 0 -> no shift
        run_op(3'd3, 8'h7C, 16'h0, 40'h9A_BCDE_F012, "R5");   // field 60 -> right 4
        run_op(3'd3, 8'hFC, 16'h0, 40'h9A_BCDE_F012, "R5");   // arith right 4
        run_op(3'd3, 8'h41, 16'h0, 40'hFF_FFFF_FFFF, "R10");  // right 63 -> 0
        run_op(3'd3, 8'hC1, 16'h0, 40'h80_0000_0000, "R10");  // arith right 63 -> all ones
        run_op(3'd3, 8'h28, 16'h0, 40'hFF_FFFF_FFFF, "R10");  // left 40 -> 0
        run_op(3'd3, 8'h27, 16'h0, 40'h00_0000_0001, "R10");  // left 39 -> bit 39
        run_op(3'd4, 8'h00, 16'h0040, 40'h12_3456_789A, "R6"); // field 0 with sign -> 0
        run_op(3'd4, 8'h00, 16'hFF81, 40'h12_3456_789A, "R6"); // upper bits ignored, +1
        run_op(3'd6, 8'h00, 16'h007F, 40'h12_3456_789A, "R6"); // -1 -> right 1
        run_op(3'd4, 8'h00, 16'h0004, 40'h80_0000_0100, "R7"); // right 4
        run_op(3'd4, 8'h00, 16'h007C, 40'h80_0000_0100, "R7"); // -4 -> left 4
        run_op(3'd5, 8'h00, 16'h0004, 40'h80_0000_0100, "R7"); // arith right 4
        run_op(3'd5, 8'h00, 16'h0041, 40'h80_0000_0100, "R7"); // -63 -> left 63
        run_op(3'd6, 8'h00, 16'h0004, 40'h80_0000_0100, "R8"); // left 4
        run_op(3'd7, 8'h00, 16'h007C, 40'h80_0000_0100, "R8"); // -4 -> arith right 4
        run_op(3'd7, 8'h00, 16'h002A, 40'h00_0000_0001, "R8"); // left 42 -> 0
        run_op(3'd1, 8'h00, 16'h0, 40'h00_0000_FFFF, "R11");  // zero result sets flag
        idle_cycles(4);                                        // R2 hold
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op = 3'($urandom);
            string t = (op < 3) ? "R3" : (op == 3) ? "R4" : (op < 6) ? "R7" : "R8";
            if ($urandom_range(3) == 0) idle_cycles(1);
            else run_op(op, 8'($urandom), 16'($urandom), {8'($urandom), 32'($urandom)}, t);
        end
        @(negedge clk); exec_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule